// File: doc/BRIEF.md
# Multi-Source XOR Parity Engine

This block runs one operation descriptor to completion. The descriptor is presented in parallel on the input ports together with a one-cycle start pulse. It holds a packed control word, a byte length, a copy-source address, a destination address and a block of address words that locate up to eight source buffers. The block then works one data word at a time. For each word index it reads every active source through a request/valid read port and folds the returned words into an accumulator with XOR. It then presents the result on a valid/ready write port at the matching destination address.

Three operation classes are accepted: a no-op that only reports completion, a plain copy of one buffer, and an XOR parity over one to eight sources. Any other mode, or an XOR descriptor with a malformed source count or buffer-enable pattern, ends with an error flag and makes no memory traffic. Completion is a one-cycle pulse, which carries the descriptor's interrupt request and the error flag.

Top module: `xor_parity_engine`

## Requirements
- R1: After reset, busy, done, doneIrq, doneErr, rdReq and wrValid are all low.
- R2: The mode sits in control bits [31:28]. Code 0 is a no-op: done rises in the second cycle after the start cycle, with doneErr low, and no read or write is issued.
- R3: Code 1 is copy. The source address is {copySrcHi[15:0], copySrcLo} and the destination address is {dstHi[15:0], dstLo}; bits [31:16] of both high words are ignored. For word i the block reads the source at base+4*i and then writes the returned word to the destination at base+4*i.
- R4: Code 6 is XOR. The source count n sits in control bits [25:22]. Source s=2k+j (j in 0..1) has low address word bufWords word 3k+j and high 16 bits in word 3k+2, bits [16j+15:16j]. Within each word index the block reads sources 0..n-1 in order, then writes their XOR to the destination.
- R5: The number of data words is ceil(byteLen/4). A byte length of zero completes without traffic and without error.
- R6: Mode codes other than 0, 1 and 6 complete with doneErr high and issue no read and no write.
- R7: An XOR descriptor completes with doneErr high and no traffic when its count is 0 or above 8, when bit 17 (parity output enable) is clear, or when bit 16 (second syndrome enable) is set.
- R8: done is a single-cycle pulse. doneIrq equals control bit 27 during that pulse, and doneErr is low for accepted descriptors.
- R9: rdReq stays high with a stable rdAddr until rdValid. wrValid stays high with stable wrAddr and wrData until wrReady.
- R10: While busy, start is ignored. The descriptor in flight runs unchanged and produces exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch the descriptor on the inputs (ignored while busy) |
| ctrlWord | input | 32 | Packed control word |
| byteLen | input | LEN_W | Byte count to process |
| copySrcLo | input | 32 | Copy source address, low 32 bits |
| copySrcHi | input | 32 | Copy source address, bits [15:0] used |
| dstLo | input | 32 | Destination address, low 32 bits |
| dstHi | input | 32 | Destination address, bits [15:0] used |
| bufWords | input | 3*MAX_SRC/2*32 | Packed XOR source address words, word j at bits [32j+31:32j] |
| rdReq | output | 1 | Read request |
| rdAddr | output | 48 | Read byte address |
| rdValid | input | 1 | Read data valid, completes the request |
| rdData | input | DATA_W | Read data |
| wrValid | output | 1 | Write request |
| wrAddr | output | 48 | Write byte address |
| wrData | output | DATA_W | Write data |
| wrReady | input | 1 | Write accepted |
| busy | output | 1 | A descriptor is in flight |
| done | output | 1 | Completion pulse |
| doneIrq | output | 1 | Interrupt request of the finished descriptor |
| doneErr | output | 1 | Descriptor rejected |

## Verification
The bench uses the default build: eight sources, 32-bit data words and a 16-bit byte length. At this size the full eight-source XOR is reachable. So are both halves of every shared high-address word, and count values 0 and 9, which sit just outside the legal range of the 4-bit field. The memory responder runs both with a grant on every cycle and with a grant on every third cycle, so the hold-while-waiting behaviour of both ports is exercised.

// File: rtl/xpe_pkg.sv
package xpe_pkg;
  localparam int ADDR_W  = 48;
  localparam int MODE_LSB = 28;
  localparam int CNT_LSB  = 22;
  localparam int CNT_W    = 4;
  localparam int BIT_IRQ  = 27;
  localparam int BIT_PAR  = 17;
  localparam int BIT_SYN  = 16;

  localparam logic [3:0] OP_NOP  = 4'd0;
  localparam logic [3:0] OP_COPY = 4'd1;
  localparam logic [3:0] OP_XOR  = 4'd6;

  typedef enum logic [2:0] {
    S_IDLE, S_DEC, S_RD, S_WR, S_FIN
  } xpe_state_t;

  typedef struct packed {
    logic latchDesc;
    logic accFirst;
    logic accEn;
    logic reading;
    logic writing;
  } xpe_strobe_t;
endpackage

// File: rtl/xpe_datapath.sv
module xpe_datapath
  import xpe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_SRC = 8,
  localparam int SEL_W  = $clog2(MAX_SRC),
  localparam int NUM_BW = 3 * MAX_SRC / 2,
  localparam int BYTES  = DATA_W / 8,
  localparam int BYTE_SH = $clog2(BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  xpe_strobe_t           strb,
  input  logic [SEL_W-1:0]      srcSel,
  input  logic [LEN_W-1:0]      wordIdx,
  input  logic [31:0]           ctrlWordIn,
  input  logic [LEN_W-1:0]      byteLenIn,
  input  logic [31:0]           copySrcLoIn,
  input  logic [31:0]           copySrcHiIn,
  input  logic [31:0]           dstLoIn,
  input  logic [31:0]           dstHiIn,
  input  logic [NUM_BW*32-1:0]  bufWordsIn,
  input  logic [DATA_W-1:0]     rdData,
  input  logic                  rdValid,
  input  logic                  wrReady,
  output logic                  decNop,
  output logic                  decErr,
  output logic                  irqReq,
  output logic [SEL_W-1:0]      lastSrc,
  output logic [LEN_W-1:0]      numWords,
  output logic [ADDR_W-1:0]     rdAddr,
  output logic [ADDR_W-1:0]     wrAddr,
  output logic [DATA_W-1:0]     wrData
);
  logic [3:0]            modeQ;
  logic [CNT_W-1:0]      cntQ;
  logic                  parQ, synQ;
  logic [LEN_W-1:0]      lenQ;
  logic [ADDR_W-1:0]     cpyQ, dstQ;
  logic [NUM_BW*32-1:0]  bufQ;
  logic [DATA_W-1:0]     acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= OP_NOP;
      cntQ  <= '0;
      parQ  <= 1'b0;
      synQ  <= 1'b0;
      irqReq <= 1'b0;
      lenQ  <= '0;
      cpyQ  <= '0;
      dstQ  <= '0;
      bufQ  <= '0;
    end else if (strb.latchDesc) begin
      modeQ <= ctrlWordIn[MODE_LSB +: 4];
      cntQ  <= ctrlWordIn[CNT_LSB +: CNT_W];
      parQ  <= ctrlWordIn[BIT_PAR];
      synQ  <= ctrlWordIn[BIT_SYN];
      irqReq <= ctrlWordIn[BIT_IRQ];
      lenQ  <= byteLenIn;
      cpyQ  <= {copySrcHiIn[15:0], copySrcLoIn};
      dstQ  <= {dstHiIn[15:0], dstLoIn};
      bufQ  <= bufWordsIn;
    end
  end

  // decode of the latched descriptor
  logic isCopy, isXor, cntOk;
  logic [CNT_W-1:0] cntM1;
  assign isCopy = (modeQ == OP_COPY);
  assign isXor  = (modeQ == OP_XOR);
  assign decNop = (modeQ == OP_NOP);
  assign cntOk  = (cntQ != '0) && (int'(cntQ) <= MAX_SRC);
  assign decErr = !(decNop || isCopy || isXor) ||
                  (isXor && (!cntOk || !parQ || synQ));
  assign cntM1  = cntQ - CNT_W'(1);
  assign lastSrc = isXor ? cntM1[SEL_W-1:0] : '0;

  logic [LEN_W:0] lenUp;
  assign lenUp    = {1'b0, lenQ} + (LEN_W+1)'(BYTES - 1);
  assign numWords = LEN_W'(lenUp >> BYTE_SH);

  // source address unpacking: pairs share one high word
  logic [ADDR_W-1:0] srcAddr [MAX_SRC];
  for (genvar i = 0; i < MAX_SRC; i++) begin : g_src
    localparam int PB = 3 * (i / 2);
    localparam int HS = 16 * (i % 2);
    assign srcAddr[i] = {bufQ[32*(PB+2)+HS +: 16], bufQ[32*(PB+(i%2)) +: 32]};
  end

  logic [ADDR_W-1:0] offs, rdBase;
  assign offs   = ADDR_W'(wordIdx) << BYTE_SH;
  assign rdBase = isCopy ? cpyQ : srcAddr[srcSel];
  assign rdAddr = rdBase + offs;
  assign wrAddr = dstQ + offs;

  always_ff @(posedge clk) begin
    if (!rstN) acc <= '0;
    else if (strb.accEn) acc <= strb.accFirst ? rdData : (acc ^ rdData);
  end
  assign wrData = acc;

  p_rdaddr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.reading && !rdValid |=> $stable(rdAddr));
  p_wr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.writing && !wrReady |=> $stable(wrAddr) && $stable(wrData));
endmodule

// File: rtl/xpe_ctrl.sv
module xpe_ctrl
  import xpe_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MAX_SRC = 8,
  localparam int SEL_W  = $clog2(MAX_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              decNop,
  input  logic              decErr,
  input  logic              irqReq,
  input  logic [SEL_W-1:0]  lastSrc,
  input  logic [LEN_W-1:0]  numWords,
  input  logic              rdValid,
  input  logic              wrReady,
  output xpe_strobe_t       strb,
  output logic [SEL_W-1:0]  srcSel,
  output logic [LEN_W-1:0]  wordIdx,
  output logic              rdReq,
  output logic              wrValid,
  output logic              busy,
  output logic              done,
  output logic              doneIrq,
  output logic              doneErr
);
  xpe_state_t state;
  logic errQ;
  logic [LEN_W-1:0] lastWord;
  assign lastWord = numWords - LEN_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      errQ    <= 1'b0;
      srcSel  <= '0;
      wordIdx <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) state <= S_DEC;
        S_DEC: begin
          errQ    <= decErr;
          srcSel  <= '0;
          wordIdx <= '0;
          if (decErr || decNop || numWords == '0) state <= S_FIN;
          else state <= S_RD;
        end
        S_RD: if (rdValid) begin
          if (srcSel == lastSrc) state <= S_WR;
          else srcSel <= srcSel + SEL_W'(1);
        end
        S_WR: if (wrReady) begin
          srcSel <= '0;
          if (wordIdx == lastWord) state <= S_FIN;
          else begin
            wordIdx <= wordIdx + LEN_W'(1);
            state   <= S_RD;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.latchDesc = (state == S_IDLE) && start;
    strb.accFirst  = (srcSel == '0);
    strb.accEn     = (state == S_RD) && rdValid;
    strb.reading   = (state == S_RD);
    strb.writing   = (state == S_WR);
  end

  assign rdReq   = (state == S_RD);
  assign wrValid = (state == S_WR);
  assign busy    = (state != S_IDLE);
  assign done    = (state == S_FIN);
  assign doneIrq = done && irqReq;
  assign doneErr = done && errQ;

  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdValid |=> rdReq);
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && !wrReady |=> wrValid);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_err_done_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEC) && decErr |=> done && doneErr);
  p_nop_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEC) && decNop |=> done && !doneErr);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneErr |-> !rdReq && !wrValid);
endmodule

// File: rtl/xor_parity_engine.sv
module xor_parity_engine
  import xpe_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int LEN_W   = 16,
  parameter int MAX_SRC = 8,
  localparam int SEL_W  = $clog2(MAX_SRC),
  localparam int NUM_BW = 3 * MAX_SRC / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [31:0]          ctrlWord,
  input  logic [LEN_W-1:0]     byteLen,
  input  logic [31:0]          copySrcLo,
  input  logic [31:0]          copySrcHi,
  input  logic [31:0]          dstLo,
  input  logic [31:0]          dstHi,
  input  logic [NUM_BW*32-1:0] bufWords,
  output logic                 rdReq,
  output logic [47:0]          rdAddr,
  input  logic                 rdValid,
  input  logic [DATA_W-1:0]    rdData,
  output logic                 wrValid,
  output logic [47:0]          wrAddr,
  output logic [DATA_W-1:0]    wrData,
  input  logic                 wrReady,
  output logic                 busy,
  output logic                 done,
  output logic                 doneIrq,
  output logic                 doneErr
);
  xpe_strobe_t       strb;
  logic [SEL_W-1:0]  srcSel, lastSrc;
  logic [LEN_W-1:0]  wordIdx, numWords;
  logic              decNop, decErr, irqReq;

  xpe_ctrl #(.LEN_W(LEN_W), .MAX_SRC(MAX_SRC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .decNop(decNop), .decErr(decErr), .irqReq(irqReq),
    .lastSrc(lastSrc), .numWords(numWords),
    .rdValid(rdValid), .wrReady(wrReady),
    .strb(strb), .srcSel(srcSel), .wordIdx(wordIdx),
    .rdReq(rdReq), .wrValid(wrValid), .busy(busy),
    .done(done), .doneIrq(doneIrq), .doneErr(doneErr)
  );

  xpe_datapath #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_SRC(MAX_SRC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcSel(srcSel), .wordIdx(wordIdx),
    .ctrlWordIn(ctrlWord), .byteLenIn(byteLen),
    .copySrcLoIn(copySrcLo), .copySrcHiIn(copySrcHi),
    .dstLoIn(dstLo), .dstHiIn(dstHi), .bufWordsIn(bufWords),
    .rdData(rdData), .rdValid(rdValid), .wrReady(wrReady),
    .decNop(decNop), .decErr(decErr), .irqReq(irqReq),
    .lastSrc(lastSrc), .numWords(numWords),
    .rdAddr(rdAddr), .wrAddr(wrAddr), .wrData(wrData)
  );
endmodule

// File: tb/xor_parity_engine_test.sv
module xor_parity_engine_test;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAX_SRC = 8;
  localparam int NUM_BW = 3 * MAX_SRC / 2;

  logic clk = 0, rstN = 0, start = 0;
  logic [31:0] ctrlWord = 0, copySrcLo = 0, copySrcHi = 0, dstLo = 0, dstHi = 0;
  logic [LEN_W-1:0] byteLen = 0;
  logic [NUM_BW*32-1:0] bufWords = 0;
  logic rdReq, wrValid, busy, done, doneIrq, doneErr;
  logic rdValid = 0, wrReady = 0;
  logic [DATA_W-1:0] rdData = 0, wrData;
  logic [47:0] rdAddr, wrAddr;

  xor_parity_engine #(.DATA_W(DATA_W), .LEN_W(LEN_W), .MAX_SRC(MAX_SRC)) uut (
    .clk(clk), .rstN(rstN), .start(start), .ctrlWord(ctrlWord), .byteLen(byteLen),
    .copySrcLo(copySrcLo), .copySrcHi(copySrcHi), .dstLo(dstLo), .dstHi(dstHi),
    .bufWords(bufWords), .rdReq(rdReq), .rdAddr(rdAddr), .rdValid(rdValid),
    .rdData(rdData), .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .busy(busy), .done(done), .doneIrq(doneIrq), .doneErr(doneErr)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0, gapMod = 1, doneCount = 0;
  string curReq = "R1";
  logic [47:0] rdQ[$];
  logic [47:0] wrAQ[$];
  logic [31:0] wrDQ[$];
  logic [31:0] bw [NUM_BW];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] memf(input logic [47:0] a);
    return (a[31:0] * 32'h9E3779B1) ^ {a[47:32], a[15:0]} ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] mkCtrl(input int mode, input int n,
                                         input bit par, input bit syn, input bit irq);
    logic [31:0] c;
    c = 32'(mode) << 28;
    c |= (32'(n) & 32'hF) << 22;
    c[17] = par;
    c[16] = syn;
    c[27] = irq;
    return c;
  endfunction

  function automatic logic [47:0] srcAddrOf(input int s);
    int k, j;
    logic [31:0] hw;
    k = s / 2; j = s % 2;
    hw = bw[3*k+2] >> (16*j);
    return {hw[15:0], bw[3*k+j]};
  endfunction

  // memory responder and on-clock comparison with the reference queues
  always @(negedge clk) begin
    cyc++;
    rdValid = 0;
    wrReady = 0;
    if (done) doneCount++;
    if (rdReq && wrValid) chk(0, "R9", "read and write together", 1, 0);
    if (rdReq && (cyc % gapMod == 0)) begin
      rdValid = 1;
      rdData = memf(rdAddr);
      if (rdQ.size() == 0) chk(0, curReq, "unexpected read", 64'(rdAddr), 0);
      else begin
        chk(rdAddr == rdQ[0], curReq, "read address", 64'(rdAddr), 64'(rdQ[0]));
        void'(rdQ.pop_front());
      end
    end
    if (wrValid && (cyc % gapMod == 0)) begin
      wrReady = 1;
      if (wrAQ.size() == 0) chk(0, curReq, "unexpected write", 64'(wrAddr), 0);
      else begin
        chk(wrAddr == wrAQ[0], curReq, "write address", 64'(wrAddr), 64'(wrAQ[0]));
        chk(wrData == wrDQ[0], curReq, "write data", 64'(wrData), 64'(wrDQ[0]));
        void'(wrAQ.pop_front());
        void'(wrDQ.pop_front());
      end
    end
  end

  // kind: 0 no traffic, 1 copy, 2 xor over n sources
  task automatic runDesc(input logic [31:0] ctrl, input int len, input int kind,
                         input int n, input bit expErr, input string req,
                         input int hold, output int lat);
    int nw, d0;
    bit seen;
    logic [47:0] cpyA, dstA, a;
    logic [31:0] acc;
    curReq = req;
    rdQ.delete(); wrAQ.delete(); wrDQ.delete();
    for (int j = 0; j < NUM_BW; j++) bufWords[32*j +: 32] = bw[j];
    cpyA = {copySrcHi[15:0], copySrcLo};
    dstA = {dstHi[15:0], dstLo};
    nw = (len + 3) / 4;
    for (int w = 0; w < nw && kind != 0; w++) begin
      acc = 0;
      for (int s = 0; s < ((kind == 1) ? 1 : n); s++) begin
        a = ((kind == 1) ? cpyA : srcAddrOf(s)) + 48'(4 * w);
        rdQ.push_back(a);
        acc ^= memf(a);
      end
      wrAQ.push_back(dstA + 48'(4 * w));
      wrDQ.push_back(acc);
    end
    @(negedge clk);
    ctrlWord = ctrl; byteLen = LEN_W'(len); start = 1;
    d0 = doneCount;
    seen = 0; lat = 0;
    while (!seen && lat < 3000) begin
      @(negedge clk); #1;
      lat++;
      if (lat >= hold) start = 0;
      if (hold > 1 && lat == 1) ctrlWord = 32'h2000_0000;
      if (hold > 1 && lat < hold) chk(busy, "R10", "busy while start held", 64'(busy), 1);
      if (done) begin
        seen = 1;
        chk(doneErr == expErr, expErr ? req : "R8", "doneErr", 64'(doneErr), 64'(expErr));
        chk(doneIrq == ctrl[27], "R8", "doneIrq", 64'(doneIrq), 64'(ctrl[27]));
      end
    end
    start = 0;
    chk(seen, req, "done seen (watchdog)", 64'(seen), 1);
    chk(rdQ.size() == 0, req, "reads left", 64'(rdQ.size()), 0);
    chk(wrAQ.size() == 0, req, "writes left", 64'(wrAQ.size()), 0);
    repeat (3) @(negedge clk);
    #1;
    chk(doneCount == d0 + 1, "R8", "done pulse count", 64'(doneCount - d0), 1);
  endtask

  initial begin
    #(10 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int lat;
    for (int j = 0; j < NUM_BW; j++) bw[j] = 32'h1000_0000 * (j + 1) + 32'h0300_0040 * j;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !doneIrq && !doneErr, "R1", "status after reset",
        {busy, done, doneIrq, doneErr}, 0);
    chk(!rdReq && !wrValid, "R1", "ports after reset", {rdReq, wrValid}, 0);
    rstN = 1;
    @(negedge clk);

    // R3 copy, masked high words, irq requested
    copySrcLo = 32'h0000_1000; copySrcHi = 32'hDEAD_0012;
    dstLo = 32'h0008_0000; dstHi = 32'hBEEF_00A0;
    runDesc(mkCtrl(1, 5, 0, 0, 1), 12, 1, 1, 0, "R3", 1, lat);
    // R5 rounding of a partial word, slow responder
    gapMod = 3;
    runDesc(mkCtrl(1, 0, 0, 0, 0), 5, 1, 1, 0, "R5", 1, lat);
    // R4 eight sources
    runDesc(mkCtrl(6, 8, 1, 0, 1), 8, 2, 8, 0, "R4", 1, lat);
    gapMod = 1;
    runDesc(mkCtrl(6, 1, 1, 0, 0), 16, 2, 1, 0, "R4", 1, lat);
    runDesc(mkCtrl(6, 3, 1, 0, 0), 7, 2, 3, 0, "R4", 1, lat);
    // R2 no-op latency
    runDesc(mkCtrl(0, 0, 0, 0, 1), 64, 0, 0, 0, "R2", 1, lat);
    chk(lat == 2, "R2", "no-op done latency", 64'(lat), 2);
    // R6 unsupported modes
    runDesc(mkCtrl(2, 1, 1, 0, 0), 8, 0, 0, 1, "R6", 1, lat);
    runDesc(mkCtrl(5, 1, 1, 0, 1), 8, 0, 0, 1, "R6", 1, lat);
    runDesc(mkCtrl(7, 2, 1, 1, 0), 8, 0, 0, 1, "R6", 1, lat);
    runDesc(mkCtrl(8, 2, 1, 0, 0), 8, 0, 0, 1, "R6", 1, lat);
    // R7 malformed XOR descriptors
    runDesc(mkCtrl(6, 0, 1, 0, 0), 8, 0, 0, 1, "R7", 1, lat);
    runDesc(mkCtrl(6, 9, 1, 0, 0), 8, 0, 0, 1, "R7", 1, lat);
    runDesc(mkCtrl(6, 2, 0, 0, 0), 8, 0, 0, 1, "R7", 1, lat);
    runDesc(mkCtrl(6, 2, 1, 1, 0), 8, 0, 0, 1, "R7", 1, lat);
    // R5 zero length
    runDesc(mkCtrl(1, 0, 0, 0, 0), 0, 0, 0, 0, "R5", 1, lat);
    // R10 start held high and descriptor changed while busy
    runDesc(mkCtrl(1, 0, 0, 0, 1), 12, 1, 1, 0, "R10", 5, lat);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule